// File: doc/BRIEF.md
# Self-Triggered Pulse Hit Stamper

This block watches one detector channel's stream of digitized samples and finds pulses without any external trigger. It tracks and subtracts a slowly drifting baseline, compares each corrected sample against a programmable threshold, and turns every pulse into one hit record. Each record holds the pulse amplitude and an arrival time: a coarse part taken from a free-running absolute time counter shared across the chip, and a 4-bit fraction of the sample period.

Arrival time is chosen by a mode input. In leading-edge mode, linear interpolation across the threshold crossing gives the time. In peak mode, the time is that of the highest sample. Records go into a small FIFO and leave on a valid/ready stream toward a concentrator. Every hit is forwarded; nothing is filtered. When the FIFO is full, a new hit is lost, and a saturating counter records the loss.

Top module: `pulse_hit_stamper`

## Requirements
- R1: Hits are generated only from the sample stream. A pulse whose corrected sample reaches the threshold (corrected >= cfg_thresh) yields exactly one hit, and a run of samples that all stay below the threshold yields none.
- R2: The corrected sample is max(0, sample - baseline). When tracking is on and the sample is below threshold outside a pulse, the baseline is updated on each valid sample as baseline += (sample - baseline) >>> 4, with an arithmetic (flooring) shift. After reset the baseline is 0.
- R3: The baseline does not change while a pulse is in progress, including on the sample that ends the pulse.
- R4: hit_amp is the largest corrected sample seen while the pulse stays at or above the threshold.
- R5: In leading-edge mode (cfg_peak_mode = 0), hit_time[TW+3:4] is the timestamp of the last sample below threshold, p. hit_time[3:0] is min(15, floor(16*(thr - p)/(c - p))), where c is the first corrected sample at or above threshold.
- R6: In peak mode (cfg_peak_mode = 1), hit_time[TW+3:4] is the timestamp of the first sample that holds the maximum, and hit_time[3:0] is 0.
- R7: A hit is produced only when the first sample below threshold after a pulse arrives. No hit is visible while the pulse is still above threshold.
- R8: After a pulse ends, cfg_holdoff consecutive below-threshold samples must arrive before a new pulse can start. An above-threshold sample in that window produces no hit and restarts the count. A value of 0 means there is no hold-off.
- R9: After reset hit_valid is 0. Hits leave in the order they were found. While hit_valid is 1 and hit_ready is 0, the presented record holds steady.
- R10: A hit that finds the FIFO full is discarded, and drop_count increments by one, saturating at its all-ones value. After reset it is 0.
- R11: When cfg_bl_track is 0, the baseline holds its value whatever samples arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SW | Raw ADC sample |
| time_now | input | TW | Absolute time counter value for this sample |
| cfg_thresh | input | SW | Threshold on the corrected sample (at least 1) |
| cfg_peak_mode | input | 1 | 0 = leading-edge timing, 1 = peak timing |
| cfg_bl_track | input | 1 | 1 = baseline follows quiet samples |
| cfg_holdoff | input | HOLD_W | Quiet samples needed after a pulse before re-arming |
| hit_valid | output | 1 | Hit record available |
| hit_ready | input | 1 | Downstream accepts the record |
| hit_amp | output | SW | Hit amplitude |
| hit_time | output | TW+4 | Coarse timestamp and 4-bit fraction |
| drop_count | output | DROP_W | Saturating count of hits lost to a full FIFO |

## Verification
The bench builds the block with 10-bit samples, a 16-bit time counter, a 4-entry FIFO, a 2-bit drop counter and a 4-bit hold-off field. With only four entries, a few stalled pulses fill the FIFO. With the 2-bit counter, the drop count reaches saturation after a handful of extra pulses, so both the discard path and the saturation are exercised. The 10-bit range leaves room to build a nonzero baseline and still place distinct pulse heights above it. That range also makes the interpolation cases easy to set up, including the one where the fraction is capped at 15.

// File: rtl/phs_pkg.sv
// Shared definitions for the pulse hit stamper.
// Assumes nothing beyond IEEE 1800-2017.
package phs_pkg;
    localparam int FRAC_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } phs_state_e;
endpackage

// File: rtl/phs_baseline.sv
// Baseline restorer: a running average that moves 1/16 of the gap toward
// each quiet sample. Assumes the caller raises freeze for samples that
// belong to a pulse.
module phs_baseline #(
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic          track_en,
    input  logic          freeze,
    output logic [SW-1:0] bl_q
);
    localparam int DW = SW + 2;

    logic signed [DW-1:0] gap;
    logic signed [DW-1:0] step;

    // Signed distance from the estimate and its 1/16 share (floor).
    always_comb begin
        gap  = $signed({2'b00, smp_data}) - $signed({2'b00, bl_q});
        step = gap >>> 4;
    end

    // Update the estimate on quiet samples while tracking is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_q <= '0;
        end else if (smp_valid && track_en && !freeze) begin
            bl_q <= bl_q + SW'(step);
        end
    end
endmodule

// File: rtl/phs_frac_interp.sv
// Fine-time interpolator: computes floor(16*num/den) by restoring
// division, one quotient bit per stage. Assumes num <= den; num == den
// gives 15, the cap.
module phs_frac_interp #(
    parameter int SW = 12
) (
    input  logic [SW-1:0]               num,
    input  logic [SW-1:0]               den,
    output logic [phs_pkg::FRAC_W-1:0]  frac
);
    localparam int NQ = phs_pkg::FRAC_W;

    logic [SW-1:0] rem [NQ];

    assign rem[0] = num;

    for (genvar i = 0; i < NQ; i++) begin : g_stage
        logic [SW:0] shifted;
        logic        fits;
        // One restoring step: double the remainder, subtract if it fits.
        always_comb begin
            shifted = {rem[i], 1'b0};
            fits    = shifted >= {1'b0, den};
        end
        assign frac[NQ-1-i] = fits;
        if (i < NQ - 1) begin : g_next
            assign rem[i+1] = fits ? SW'(shifted - {1'b0, den}) : SW'(shifted);
        end
    end
endmodule

// File: rtl/phs_finder.sv
// Hit finder: a three-state machine (idle, pulse, hold-off) that measures
// each pulse and emits one record when the pulse ends. Assumes corrected
// samples and the threshold flag arrive with smp_valid, and that the
// threshold is at least 1.
module phs_finder #(
    parameter int SW     = 12,
    parameter int TW     = 32,
    parameter int HOLD_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           smp_valid,
    input  logic [SW-1:0]                  corr,
    input  logic                           above,
    input  logic [TW-1:0]                  stamp,
    input  logic [SW-1:0]                  thresh,
    input  logic                           peak_mode,
    input  logic [HOLD_W-1:0]              holdoff,
    output logic                           busy,
    output logic                           push,
    output logic [SW-1:0]                  push_amp,
    output logic [TW+phs_pkg::FRAC_W-1:0]  push_time
);
    import phs_pkg::*;

    phs_state_e                state_q;
    logic [SW-1:0]             prev_c_q;
    logic [TW-1:0]             prev_t_q;
    logic [SW-1:0]             max_q;
    logic [TW-1:0]             max_t_q;
    logic [TW+FRAC_W-1:0]      edge_time_q;
    logic [HOLD_W-1:0]         hcnt_q;
    logic [HOLD_W-1:0]         hcnt_nx;
    logic [SW-1:0]             lerp_num;
    logic [SW-1:0]             lerp_den;
    logic [FRAC_W-1:0]         frac;

    // Operands of the crossing interpolation between the previous and current sample.
    always_comb begin
        lerp_num = thresh - prev_c_q;
        lerp_den = corr - prev_c_q;
        hcnt_nx  = hcnt_q + 1'b1;
    end

    phs_frac_interp #(.SW(SW)) u_lerp (
        .num  (lerp_num),
        .den  (lerp_den),
        .frac (frac)
    );

    assign busy = (state_q == ST_PULSE);

    // Pulse tracking, record assembly and hold-off counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            prev_c_q    <= '0;
            prev_t_q    <= '0;
            max_q       <= '0;
            max_t_q     <= '0;
            edge_time_q <= '0;
            hcnt_q      <= '0;
            push        <= 1'b0;
            push_amp    <= '0;
            push_time   <= '0;
        end else begin
            push <= 1'b0;
            if (smp_valid) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (above) begin
                            state_q     <= ST_PULSE;
                            max_q       <= corr;
                            max_t_q     <= stamp;
                            edge_time_q <= {prev_t_q, frac};
                        end
                    end
                    ST_PULSE: begin
                        if (above) begin
                            if (corr > max_q) begin
                                max_q   <= corr;
                                max_t_q <= stamp;
                            end
                        end else begin
                            push      <= 1'b1;
                            push_amp  <= max_q;
                            push_time <= peak_mode ? {max_t_q, {FRAC_W{1'b0}}}
                                                   : edge_time_q;
                            hcnt_q    <= '0;
                            state_q   <= (holdoff == '0) ? ST_IDLE : ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        if (above) begin
                            hcnt_q <= '0;
                        end else if (hcnt_nx == holdoff) begin
                            state_q <= ST_IDLE;
                        end else begin
                            hcnt_q <= hcnt_nx;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
                prev_c_q <= corr;
                prev_t_q <= stamp;
            end
        end
    end
endmodule

// File: rtl/phs_fifo.sv
// Hit queue: first-word-fall-through FIFO with a saturating loss counter.
// Assumes DEPTH is a power of two. A write that finds it full is discarded.
module phs_fifo #(
    parameter int RW     = 16,
    parameter int DEPTH  = 8,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [RW-1:0]     rd_data,
    output logic [DROP_W-1:0] drops
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [RW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_q;
    logic [AW-1:0] rp_q;
    logic [AW:0]   cnt_q;
    logic          full;
    logic          do_wr;
    logic          do_rd;

    // Occupancy decode and transfer qualification.
    always_comb begin
        full     = (cnt_q == (AW+1)'(DEPTH));
        rd_valid = (cnt_q != '0);
        do_wr    = wr_en && !full;
        do_rd    = rd_valid && rd_ready;
        rd_data  = mem_q[rp_q];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_wr) mem_q[wp_q] <= wr_data;
    end

    // Pointers, occupancy and the saturating loss counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            drops <= '0;
        end else begin
            if (do_wr) wp_q <= wp_q + 1'b1;
            if (do_rd) rp_q <= rp_q + 1'b1;
            if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
            else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
            if (wr_en && full && (drops != {DROP_W{1'b1}})) drops <= drops + 1'b1;
        end
    end
endmodule

// File: rtl/pulse_hit_stamper.sv
// Top of the self-triggered hit stamper: baseline correction, threshold
// compare, hit finding and the output queue. Assumes one sample per
// smp_valid and a time_now value that belongs to that sample.
module pulse_hit_stamper #(
    parameter int SW     = 12,
    parameter int TW     = 32,
    parameter int DEPTH  = 8,
    parameter int DROP_W = 8,
    parameter int HOLD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SW-1:0]       smp_data,
    input  logic [TW-1:0]       time_now,
    input  logic [SW-1:0]       cfg_thresh,
    input  logic                cfg_peak_mode,
    input  logic                cfg_bl_track,
    input  logic [HOLD_W-1:0]   cfg_holdoff,
    output logic                hit_valid,
    input  logic                hit_ready,
    output logic [SW-1:0]       hit_amp,
    output logic [TW+3:0]       hit_time,
    output logic [DROP_W-1:0]   drop_count
);
    localparam int TFW = TW + phs_pkg::FRAC_W;
    localparam int RW  = SW + TFW;

    logic [SW-1:0]  bl_q;
    logic [SW:0]    diff;
    logic [SW-1:0]  corr;
    logic           above;
    logic           fin_busy;
    logic           fin_push;
    logic [SW-1:0]  fin_amp;
    logic [TFW-1:0] fin_time;
    logic [RW-1:0]  q_data;

    // Baseline subtraction clamped at zero, then threshold compare.
    always_comb begin
        diff  = {1'b0, smp_data} - {1'b0, bl_q};
        corr  = diff[SW] ? '0 : diff[SW-1:0];
        above = (corr >= cfg_thresh);
    end

    phs_baseline #(.SW(SW)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .track_en  (cfg_bl_track),
        .freeze    (above || fin_busy),
        .bl_q      (bl_q)
    );

    phs_finder #(.SW(SW), .TW(TW), .HOLD_W(HOLD_W)) u_find (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .corr      (corr),
        .above     (above),
        .stamp     (time_now),
        .thresh    (cfg_thresh),
        .peak_mode (cfg_peak_mode),
        .holdoff   (cfg_holdoff),
        .busy      (fin_busy),
        .push      (fin_push),
        .push_amp  (fin_amp),
        .push_time (fin_time)
    );

    phs_fifo #(.RW(RW), .DEPTH(DEPTH), .DROP_W(DROP_W)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fin_push),
        .wr_data  ({fin_time, fin_amp}),
        .rd_valid (hit_valid),
        .rd_ready (hit_ready),
        .rd_data  (q_data),
        .drops    (drop_count)
    );

    assign hit_amp  = q_data[SW-1:0];
    assign hit_time = q_data[RW-1:SW];
endmodule

// File: rtl/phs_checker.sv
// Property checker for pulse_hit_stamper, attached through bind.
// Assumes the top's internal names bl_q, fin_busy and fin_push.
module phs_checker #(
    parameter int SW     = 12,
    parameter int TW     = 32,
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic              cfg_bl_track,
    input logic              hit_valid,
    input logic              hit_ready,
    input logic [SW-1:0]     hit_amp,
    input logic [TW+3:0]     hit_time,
    input logic [DROP_W-1:0] drop_count,
    input logic [SW-1:0]     bl_q,
    input logic              fin_busy,
    input logic              fin_push
);
    p_push_from_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fin_push |-> $past(smp_valid));

    p_bl_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fin_busy |=> $stable(bl_q));

    p_bl_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bl_track |=> $stable(bl_q));

    p_head_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_amp) && $stable(hit_time)));

    p_drop_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (drop_count >= $past(drop_count)));

    p_drop_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == {DROP_W{1'b1}}) |=> (drop_count == {DROP_W{1'b1}}));
endmodule

bind pulse_hit_stamper phs_checker #(.SW(SW), .TW(TW), .DROP_W(DROP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .cfg_bl_track (cfg_bl_track),
    .hit_valid    (hit_valid),
    .hit_ready    (hit_ready),
    .hit_amp      (hit_amp),
    .hit_time     (hit_time),
    .drop_count   (drop_count),
    .bl_q         (bl_q),
    .fin_busy     (fin_busy),
    .fin_push     (fin_push)
);

// File: tb/pulse_hit_stamper_bench.sv
module pulse_hit_stamper_bench;
    localparam int SW = 10;
    localparam int TW = 16;
    localparam int DEPTH = 4;
    localparam int DROP_W = 2;
    localparam int HOLD_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [SW-1:0]     smp_data = '0;
    logic [TW-1:0]     time_now = '0;
    logic [SW-1:0]     cfg_thresh = 10'd100;
    logic              cfg_peak_mode = 1'b0;
    logic              cfg_bl_track = 1'b0;
    logic [HOLD_W-1:0] cfg_holdoff = '0;
    logic              hit_valid;
    logic              hit_ready = 1'b0;
    logic [SW-1:0]     hit_amp;
    logic [TW+3:0]     hit_time;
    logic [DROP_W-1:0] drop_count;

    int n_chk = 0;
    int n_bad = 0;
    int tnow = 100;
    int bl_m = 0;

    always #10 clk = ~clk;

    pulse_hit_stamper #(.SW(SW), .TW(TW), .DEPTH(DEPTH), .DROP_W(DROP_W), .HOLD_W(HOLD_W))
    u_pulse_hit_stamper (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .time_now(time_now), .cfg_thresh(cfg_thresh), .cfg_peak_mode(cfg_peak_mode),
        .cfg_bl_track(cfg_bl_track), .cfg_holdoff(cfg_holdoff), .hit_valid(hit_valid),
        .hit_ready(hit_ready), .hit_amp(hit_amp), .hit_time(hit_time), .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int corr_of(input int v, input int b);
        return (v > b) ? v - b : 0;
    endfunction

    function automatic int frac_of(input int thr, input int p, input int c);
        int f = (16 * (thr - p)) / (c - p);
        return (f > 15) ? 15 : f;
    endfunction

    // One sample on the bus; returns the timestamp it carried.
    task automatic send(input int v, output int ts);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = v[SW-1:0];
        time_now  = tnow[TW-1:0];
        ts = tnow;
        @(negedge clk);
        smp_valid = 1'b0;
        tnow += 7;
    endtask

    task automatic send_n(input int v);
        int ts;
        send(v, ts);
    endtask

    task automatic expect_none(input string tag);
        repeat (6) @(negedge clk);
        check(hit_valid == 1'b0, tag, int'(hit_valid), 0);
    endtask

    task automatic expect_hit(input int amp, input int coarse, input int frac, input string tag);
        int waited = 0;
        while (!hit_valid && waited < 30) begin
            @(negedge clk);
            waited++;
        end
        check(hit_valid == 1'b1, {tag, " valid"}, int'(hit_valid), 1);
        check(int'(hit_amp) == amp, {tag, " amp"}, int'(hit_amp), amp);
        check(int'(hit_time[TW+3:4]) == (coarse & 16'hFFFF), {tag, " coarse"},
              int'(hit_time[TW+3:4]), coarse & 16'hFFFF);
        check(int'(hit_time[3:0]) == frac, {tag, " frac"}, int'(hit_time[3:0]), frac);
        hit_ready = 1'b1;
        @(negedge clk);
        hit_ready = 1'b0;
    endtask

    task automatic t_reset();
        check(hit_valid == 1'b0, "R9 reset valid", int'(hit_valid), 0);
        check(drop_count == '0, "R10 reset drops", int'(drop_count), 0);
    endtask

    task automatic t_quiet();
        send_n(0); send_n(50); send_n(99); send_n(0);
        expect_none("R1 sub-threshold");
    endtask

    task automatic t_leading_edge();
        int t1, ts;
        cfg_peak_mode = 1'b0;
        send_n(0); send(40, t1); send_n(200); send_n(300); send_n(250);
        expect_none("R7 no hit mid-pulse");
        send(10, ts);
        expect_hit(300, t1, frac_of(100, 40, 200), "R5 R4 R1 leading edge");
    endtask

    task automatic t_peak();
        int ta, ts;
        cfg_peak_mode = 1'b1;
        send_n(0); send_n(150); send(400, ta); send_n(400); send_n(120); send(0, ts);
        expect_hit(400, ta, 0, "R6 R4 peak");
        cfg_peak_mode = 1'b0;
    endtask

    task automatic t_frac_cap();
        int tp;
        send(99, tp); send_n(100); send_n(0);
        expect_hit(100, tp, 15, "R5 fraction cap");
    endtask

    task automatic t_holdoff();
        int tq, tr;
        cfg_holdoff = 4'd3;
        send_n(0); send(0, tq); send_n(200); send_n(0);
        expect_hit(200, tq, frac_of(100, 0, 200), "R8 first pulse");
        send_n(0); send_n(250); send_n(0); send_n(0); send(0, tr);
        expect_none("R8 retrigger ignored");
        send_n(300); send_n(0);
        expect_hit(300, tr, frac_of(100, 0, 300), "R8 re-armed");
        cfg_holdoff = '0;
    endtask

    task automatic t_baseline();
        int tl, ts, amp, p;
        cfg_bl_track = 1'b1;
        bl_m = 0;
        for (int i = 0; i < 40; i++) begin
            send(64, tl);
            bl_m += (64 - bl_m) >>> 4;
        end
        send_n(314); send_n(364); send(64, ts);
        p = corr_of(64, bl_m);
        amp = 364 - bl_m;
        expect_hit(amp, tl, frac_of(100, p, 314 - bl_m), "R2 R3 tracked baseline");
        cfg_bl_track = 1'b0;
        for (int i = 0; i < 5; i++) send(0, tl);
        send_n(364); send_n(0);
        expect_hit(364 - bl_m, tl, frac_of(100, 0, 364 - bl_m), "R11 baseline held");
    endtask

    task automatic t_overflow();
        int tz [8];
        int ts;
        int amp0;
        for (int k = 0; k < 6; k++) begin
            send(0, tz[k]); send_n(400 + 10 * k); send_n(0);
        end
        repeat (4) @(negedge clk);
        check(int'(drop_count) == 2, "R10 drops counted", int'(drop_count), 2);
        amp0 = int'(hit_amp);
        repeat (5) @(negedge clk);
        check(int'(hit_amp) == amp0 && hit_valid, "R9 head steady", int'(hit_amp), amp0);
        for (int k = 6; k < 8; k++) begin
            send(0, tz[k]); send_n(400 + 10 * k); send(0, ts);
        end
        repeat (4) @(negedge clk);
        check(int'(drop_count) == 3, "R10 saturated", int'(drop_count), 3);
        for (int k = 0; k < 4; k++) begin
            expect_hit(400 + 10 * k - bl_m, tz[k], frac_of(100, 0, 400 + 10 * k - bl_m),
                       "R9 order");
        end
        expect_none("R10 dropped hits absent");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quiet();
        t_leading_edge();
        t_peak();
        t_frac_cap();
        t_holdoff();
        t_baseline();
        t_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule